// File: doc/BRIEF.md
# Page-Mapped External Memory Translation Table

This block is a single-level translation table that sits in front of an external-memory cache. It turns virtual addresses into physical addresses. Two virtual windows share one 16 MB linear space: an instruction window based at 0x4200_0000 and a data window based at 0x3C00_0000. The linear address is the low 24 bits of the virtual address. The page size can be changed at run time to 16 KB, 32 KB or 64 KB. This moves the boundary between the page-index bits and the page-offset bits.

Software maintains the table through a register-style command port. The commands map an entry, invalidate an entry, read an entry back (both the raw word and its physical base), and clear the whole table in one cycle. A translate port returns one registered result per request. Each result is either a hit with a physical address or a fault with a zero address.

A reverse-search engine steps through the table one entry per cycle, starting at index 0. It reports the first valid entry that holds a requested physical page number, or a not-found result. A purely combinational region checker says whether a virtual byte range lies wholly inside one of the permitted windows.

Top module: `xmem_page_map`

## Requirements
- R1: The page-size code is set by `cfg_we`/`cfg_psize` and takes effect from the next cycle. Code 0 gives a 14-bit page offset, code 1 a 15-bit offset, and codes 2 and 3 a 16-bit offset. The entry index is the linear address (vaddr & 0x00FF_FFFF) shifted right by the offset width.
- R2: The map command (`reg_op`=0) stores an entry word with the page number (paddr >> shift) in bits 13:0 and the target flag in bit 14. Bit 15 is the invalid bit and is left clear. A later read returns this word zero-extended.
- R3: The invalidate command (`reg_op`=1) stores the invalid pattern 0x0000_8000. A translation through that entry then faults.
- R4: The unmap-all command (`reg_op`=3) sets every entry to the invalid pattern in one cycle. Reset leaves every entry in the same state.
- R5: A map, invalidate or read command whose `reg_idx` is 256 or higher raises `reg_err` one cycle later. It writes nothing and gives no read data.
- R6: A translate request is answered one cycle later on `xl_rsp`. When the window matches the bus type and the entry is valid with the target flag set, `xl_hit` is 1 and `xl_paddr` = (page number << shift) | page offset.
- R7: A translation that hits an invalid entry, falls outside the window selected by `xl_is_data`, or indexes at or beyond 256 raises `xl_fault` and returns zero. `xl_hit` and `xl_fault` are never high together.
- R8: The read command (`reg_op`=2) also returns `reg_pbase`, which is the stored page number shifted left by the page shift current at read time.
- R9: The reverse search starts on `rl_start` and examines entry k in the (k+1)th cycle after start. It ends with `rl_done` and `rl_found`=1 at the lowest matching valid index.
- R10: If no entry matches, the search ends after 256 cycles with `rl_found`=0 and `rl_idx` all ones.
- R11: A start request while `rl_busy` is high is ignored. It changes neither the key, the duration nor the result of the search in progress.
- R12: `rg_ok` is 1 only when both the first byte and the last byte (start + len - 1) lie in the same permitted window. The instruction window is allowed when `rg_types` bit 0 is set, and the data window when bit 1 is set.
- R13: After reset, all response outputs are 0, the search engine is idle and the page-size code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the page-size code |
| cfg_psize | input | 2 | Page-size code |
| reg_valid | input | 1 | Command strobe |
| reg_op | input | 2 | 0 map, 1 invalidate, 2 read, 3 unmap all |
| reg_idx | input | 16 | Entry index |
| reg_paddr | input | 32 | Physical address for a map command |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Raw entry word |
| reg_pbase | output | 32 | Physical base of the entry read |
| reg_err | output | 1 | Index out of range |
| xl_req | input | 1 | Translate request |
| xl_is_data | input | 1 | 1 data bus, 0 instruction bus |
| xl_vaddr | input | 32 | Virtual address |
| xl_rsp | output | 1 | Translate response strobe |
| xl_hit | output | 1 | Translation succeeded |
| xl_fault | output | 1 | Translation failed |
| xl_paddr | output | 32 | Physical address, zero on fault |
| rl_start | input | 1 | Start reverse search |
| rl_ppn | input | 14 | Page number to find |
| rl_busy | output | 1 | Search running |
| rl_done | output | 1 | Search finished, one-cycle pulse |
| rl_found | output | 1 | Match found |
| rl_idx | output | 8 | Matching index, all ones if none |
| rg_start | input | 32 | Region first byte |
| rg_len | input | 32 | Region length in bytes |
| rg_types | input | 2 | Permitted windows: bit 0 instruction, bit 1 data |
| rg_ok | output | 1 | Region legal |

## Verification
The properties assume the control inputs are never X after reset. They also assume `rl_start` is the only way the search engine leaves idle, so a rising busy must be traced to a start strobe. Every page-size code, including the spare code 3, is treated as legal. The stimulus drives every input on the falling edge, holds each command strobe for exactly one cycle, and changes `cfg_psize` only between commands. As a result, each check sees a single, well-defined page shift.

// File: rtl/xpm_pkg.sv
package xpm_pkg;

  typedef enum logic [1:0] {
    OP_MAP   = 2'd0,
    OP_INVAL = 2'd1,
    OP_READ  = 2'd2,
    OP_UNMAP = 2'd3
  } map_op_e;

  localparam int SHIFT_W = 5;

  // offset width for a page-size code; spare code behaves as the largest page
  function automatic logic [SHIFT_W-1:0] page_shift(input logic [1:0] code);
    case (code)
      2'd0:    page_shift = 5'd14;
      2'd1:    page_shift = 5'd15;
      default: page_shift = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/xpm_xlate.sv
module xpm_xlate #(
  parameter int          AW      = 32,
  parameter int          LIN_W   = 24,
  parameter int          ENTRIES = 256,
  parameter int          PPN_W   = 14,
  parameter logic [31:0] IBASE   = 32'h4200_0000,
  parameter logic [31:0] DBASE   = 32'h3C00_0000,
  localparam int         IDX_W   = $clog2(ENTRIES),
  localparam int         ENT_W   = PPN_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic                        is_data,
  input  logic [AW-1:0]               vaddr,
  input  logic [xpm_pkg::SHIFT_W-1:0] shift,
  input  logic [ENT_W-1:0]            entry,
  output logic [IDX_W-1:0]            idx,
  output logic                        rsp,
  output logic                        hit,
  output logic                        fault,
  output logic [AW-1:0]               paddr
);
  localparam logic [AW-1:0] LIN_MASK = {{(AW-LIN_W){1'b0}}, {LIN_W{1'b1}}};
  localparam int TGT_BIT = PPN_W;
  localparam int INV_BIT = PPN_W + 1;

  logic [AW-1:0] lin, page_full, off_mask, pa_calc, paddr_n;
  logic          win_ok, in_range, ent_ok, hit_n, fault_n;

  always_comb begin
    lin       = vaddr & LIN_MASK;
    win_ok    = is_data ? ((vaddr & ~LIN_MASK) == DBASE) : ((vaddr & ~LIN_MASK) == IBASE);
    page_full = lin >> shift;
    in_range  = page_full < AW'(ENTRIES);
    idx       = page_full[IDX_W-1:0];
    ent_ok    = !entry[INV_BIT] && entry[TGT_BIT];
    off_mask  = ~({AW{1'b1}} << shift);
    pa_calc   = (AW'(entry[PPN_W-1:0]) << shift) | (lin & off_mask);
    hit_n     = req && win_ok && in_range && ent_ok;
    fault_n   = req && !hit_n;
    paddr_n   = hit_n ? pa_calc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp   <= 1'b0;
      hit   <= 1'b0;
      fault <= 1'b0;
      paddr <= '0;
    end else begin
      rsp   <= req;
      hit   <= hit_n;
      fault <= fault_n;
      paddr <= paddr_n;
    end
  end
endmodule

// File: rtl/xpm_rev_scan.sv
module xpm_rev_scan #(
  parameter int  ENTRIES = 256,
  parameter int  PPN_W   = 14,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ENT_W   = PPN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PPN_W-1:0] key,
  input  logic [ENT_W-1:0] entry,
  output logic [IDX_W-1:0] scan_idx,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [IDX_W-1:0] res_idx
);
  localparam int TGT_BIT = PPN_W;
  localparam int INV_BIT = PPN_W + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             busy_n, done_n, found_n, match;
  logic [IDX_W-1:0] idx_n, res_n;
  logic [PPN_W-1:0] key_q, key_n;

  always_comb begin
    busy_n  = busy;
    done_n  = 1'b0;
    found_n = found;
    idx_n   = scan_idx;
    res_n   = res_idx;
    key_n   = key_q;
    match   = !entry[INV_BIT] && entry[TGT_BIT] && (entry[PPN_W-1:0] == key_q);
    if (!busy) begin
      if (start) begin
        busy_n  = 1'b1;
        idx_n   = '0;
        key_n   = key;
        found_n = 1'b0;
      end
    end else if (match) begin
      busy_n  = 1'b0;
      done_n  = 1'b1;
      found_n = 1'b1;
      res_n   = scan_idx;
    end else if (scan_idx == LAST) begin
      busy_n  = 1'b0;
      done_n  = 1'b1;
      found_n = 1'b0;
      res_n   = '1;
    end else begin
      idx_n = scan_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      found    <= 1'b0;
      scan_idx <= '0;
      res_idx  <= '0;
      key_q    <= '0;
    end else begin
      busy     <= busy_n;
      done     <= done_n;
      found    <= found_n;
      scan_idx <= idx_n;
      res_idx  <= res_n;
      key_q    <= key_n;
    end
  end
endmodule

// File: rtl/xpm_region_chk.sv
module xpm_region_chk #(
  parameter int          AW    = 32,
  parameter int          LIN_W = 24,
  parameter logic [31:0] IBASE = 32'h4200_0000,
  parameter logic [31:0] DBASE = 32'h3C00_0000
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] len,
  input  logic [1:0]    types,
  output logic          ok
);
  localparam logic [AW-1:0] HI_MASK = ~{{(AW-LIN_W){1'b0}}, {LIN_W{1'b1}}};

  logic [AW-1:0] last;
  logic          i_ok, d_ok;

  always_comb begin
    last = start + len - 1'b1;
    i_ok = ((start & HI_MASK) == IBASE) && ((last & HI_MASK) == IBASE);
    d_ok = ((start & HI_MASK) == DBASE) && ((last & HI_MASK) == DBASE);
    ok   = (types[0] && i_ok) || (types[1] && d_ok);
  end
endmodule

// File: rtl/xmem_page_map.sv
module xmem_page_map #(
  parameter int          AW        = 32,
  parameter int          LIN_W     = 24,
  parameter int          ENTRIES   = 256,
  parameter int          PPN_W     = 14,
  parameter int          REG_IDX_W = 16,
  parameter logic [31:0] IBASE     = 32'h4200_0000,
  parameter logic [31:0] DBASE     = 32'h3C00_0000,
  localparam int         IDX_W     = $clog2(ENTRIES),
  localparam int         ENT_W     = PPN_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_psize,
  input  logic                 reg_valid,
  input  logic [1:0]           reg_op,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [AW-1:0]        reg_paddr,
  output logic                 reg_rvalid,
  output logic [AW-1:0]        reg_rdata,
  output logic [AW-1:0]        reg_pbase,
  output logic                 reg_err,
  input  logic                 xl_req,
  input  logic                 xl_is_data,
  input  logic [AW-1:0]        xl_vaddr,
  output logic                 xl_rsp,
  output logic                 xl_hit,
  output logic                 xl_fault,
  output logic [AW-1:0]        xl_paddr,
  input  logic                 rl_start,
  input  logic [PPN_W-1:0]     rl_ppn,
  output logic                 rl_busy,
  output logic                 rl_done,
  output logic                 rl_found,
  output logic [IDX_W-1:0]     rl_idx,
  input  logic [AW-1:0]        rg_start,
  input  logic [AW-1:0]        rg_len,
  input  logic [1:0]           rg_types,
  output logic                 rg_ok
);
  import xpm_pkg::*;

  localparam int TGT_BIT = PPN_W;
  localparam int INV_BIT = PPN_W + 1;
  localparam logic [ENT_W-1:0] INV_WORD = ENT_W'(1) << INV_BIT;

  logic [ENT_W-1:0]   tbl [ENTRIES];
  logic [1:0]         psize_q, psize_n;
  logic [SHIFT_W-1:0] shift;
  map_op_e            op;
  logic               idx_in, do_map, do_inval, do_unmap, do_read;
  logic [IDX_W-1:0]   ridx, xl_idx, scan_idx;
  logic [ENT_W-1:0]   map_word, rd_word;
  logic               rvalid_n, err_n;
  logic [AW-1:0]      rdata_n, pbase_n;

  // page-size code register
  always_comb psize_n = cfg_we ? cfg_psize : psize_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psize_q <= 2'd0;
    else        psize_q <= psize_n;
  end

  assign shift = page_shift(psize_q);

  // command decode
  always_comb begin
    op       = map_op_e'(reg_op);
    idx_in   = reg_idx < REG_IDX_W'(ENTRIES);
    ridx     = reg_idx[IDX_W-1:0];
    do_unmap = reg_valid && (op == OP_UNMAP);
    do_map   = reg_valid && (op == OP_MAP)   && idx_in;
    do_inval = reg_valid && (op == OP_INVAL) && idx_in;
    do_read  = reg_valid && (op == OP_READ)  && idx_in;
    map_word = '0;
    map_word[PPN_W-1:0] = PPN_W'(reg_paddr >> shift);
    map_word[TGT_BIT]   = 1'b1;
    rd_word  = tbl[ridx];
    rvalid_n = do_read;
    err_n    = reg_valid && (op != OP_UNMAP) && !idx_in;
    rdata_n  = do_read ? AW'(rd_word) : reg_rdata;
    pbase_n  = do_read ? (AW'(rd_word[PPN_W-1:0]) << shift) : reg_pbase;
  end

  // translation table storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= INV_WORD;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_unmap) begin
          tbl[i] <= INV_WORD;
        end else if ((do_map || do_inval) && (ridx == IDX_W'(i))) begin
          tbl[i] <= do_map ? map_word : INV_WORD;
        end
      end
    end
  end

  // command response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_err    <= 1'b0;
      reg_rdata  <= '0;
      reg_pbase  <= '0;
    end else begin
      reg_rvalid <= rvalid_n;
      reg_err    <= err_n;
      reg_rdata  <= rdata_n;
      reg_pbase  <= pbase_n;
    end
  end

  xpm_xlate #(
    .AW(AW), .LIN_W(LIN_W), .ENTRIES(ENTRIES), .PPN_W(PPN_W),
    .IBASE(IBASE), .DBASE(DBASE)
  ) u_xlate (
    .clk(clk), .rst_n(rst_n), .req(xl_req), .is_data(xl_is_data),
    .vaddr(xl_vaddr), .shift(shift), .entry(tbl[xl_idx]), .idx(xl_idx),
    .rsp(xl_rsp), .hit(xl_hit), .fault(xl_fault), .paddr(xl_paddr)
  );

  xpm_rev_scan #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .start(rl_start), .key(rl_ppn),
    .entry(tbl[scan_idx]), .scan_idx(scan_idx), .busy(rl_busy),
    .done(rl_done), .found(rl_found), .res_idx(rl_idx)
  );

  xpm_region_chk #(
    .AW(AW), .LIN_W(LIN_W), .IBASE(IBASE), .DBASE(DBASE)
  ) u_region (
    .start(rg_start), .len(rg_len), .types(rg_types), .ok(rg_ok)
  );
endmodule

// File: rtl/xmem_page_map_chk.sv
module xmem_page_map_chk #(
  parameter int  AW      = 32,
  parameter int  ENTRIES = 256,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rvalid,
  input logic             reg_err,
  input logic             xl_req,
  input logic             xl_rsp,
  input logic             xl_hit,
  input logic             xl_fault,
  input logic [AW-1:0]    xl_paddr,
  input logic             rl_start,
  input logic             rl_busy,
  input logic             rl_done,
  input logic             rl_found,
  input logic [IDX_W-1:0] rl_idx
);
  // R7
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_paddr == '0));

  // R7
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_hit && xl_fault));

  // R6
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp |-> ($past(xl_req) && (xl_hit || xl_fault)));

  // R5
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> !reg_rvalid);

  // R10
  notfound_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_done && !rl_found) |-> (rl_idx == '1));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl_done |-> !rl_busy);

  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rl_busy) |-> $past(rl_start));
endmodule

bind xmem_page_map xmem_page_map_chk #(.AW(AW), .ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/xmem_page_map_bench.sv
`timescale 1ns/1ps
module xmem_page_map_bench;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_psize;
  logic        reg_valid;
  logic [1:0]  reg_op;
  logic [15:0] reg_idx;
  logic [31:0] reg_paddr;
  logic        reg_rvalid, reg_err;
  logic [31:0] reg_rdata, reg_pbase;
  logic        xl_req, xl_is_data, xl_rsp, xl_hit, xl_fault;
  logic [31:0] xl_vaddr, xl_paddr;
  logic        rl_start, rl_busy, rl_done, rl_found;
  logic [13:0] rl_ppn;
  logic [7:0]  rl_idx;
  logic [31:0] rg_start, rg_len;
  logic [1:0]  rg_types;
  logic        rg_ok;

  int checks = 0;
  int fails  = 0;

  xmem_page_map u_xmem_page_map (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // translation vectors: page code, entry, map address, vaddr, bus, hit, expected paddr
  localparam int NV = 8;
  localparam logic [1:0]  V_PS  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd2, 2'd0, 2'd0};
  localparam logic [15:0] V_IDX [NV] = '{16'd5, 16'd7, 16'd255, 16'd1, 16'd2, 16'd4, 16'd6, 16'd0};
  localparam logic [31:0] V_PA  [NV] = '{32'h0024_0000, 32'h0038_0000, 32'h00AB_0000, 32'h0005_0000,
                                         32'h0010_0000, 32'h0020_0000, 32'h0000_0000, 32'h0000_4000};
  localparam logic [31:0] V_VA  [NV] = '{32'h4201_4123, 32'h3C03_FFFF, 32'h42FF_0010, 32'h3C01_ABCD,
                                         32'h4002_0000, 32'h4204_0000, 32'h4240_0000, 32'h4200_0000};
  localparam logic        V_DAT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] V_EXP [NV] = '{32'h0024_0123, 32'h0038_7FFF, 32'h00AB_0010, 32'h0005_ABCD,
                                         32'h0, 32'h0, 32'h0, 32'h0000_4000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic set_psize(input logic [1:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_psize = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [15:0] idx, input logic [31:0] pa);
    @(negedge clk); reg_valid = 1'b1; reg_op = op; reg_idx = idx; reg_paddr = pa;
    @(negedge clk); reg_valid = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic dat);
    @(negedge clk); xl_req = 1'b1; xl_vaddr = va; xl_is_data = dat;
    @(negedge clk); xl_req = 1'b0;
  endtask

  // runs a search; optionally pulses a second start while busy; returns cycles to done
  task automatic search(input logic [13:0] key, input bit poke, output int n);
    @(negedge clk); rl_start = 1'b1; rl_ppn = key;
    @(negedge clk); rl_start = 1'b0; rl_ppn = 14'h0;
    n = 0;
    while (!rl_done && n < 400) begin
      if (poke && n == 3) begin rl_start = 1'b1; rl_ppn = 14'h0090; end
      @(posedge clk); n++;
      @(negedge clk); rl_start = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 0; cfg_psize = 0; reg_valid = 0; reg_op = 0; reg_idx = 0;
    reg_paddr = 0; xl_req = 0; xl_is_data = 0; xl_vaddr = 0; rl_start = 0; rl_ppn = 0;
    rg_start = 0; rg_len = 0; rg_types = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 xl_hit", {31'b0, xl_hit}, 32'd0);
    chk("R13 xl_fault", {31'b0, xl_fault}, 32'd0);
    chk("R13 rl_busy", {31'b0, rl_busy}, 32'd0);
    chk("R13 reg_err", {31'b0, reg_err}, 32'd0);
    cmd(2'd2, 16'd0, 32'h0);
    chk("R4 reset entry invalid", reg_rdata, 32'h0000_8000);

    // R2 map then read back (code 0, shift 14)
    cmd(2'd0, 16'd10, 32'h0012_C000);
    cmd(2'd2, 16'd10, 32'h0);
    chk("R2 rvalid", {31'b0, reg_rvalid}, 32'd1);
    chk("R2 entry word", reg_rdata, 32'h0000_404B);
    chk("R8 pbase shift14", reg_pbase, 32'h0012_C000);
    set_psize(2'd2);
    cmd(2'd2, 16'd10, 32'h0);
    chk("R8 pbase shift16", reg_pbase, 32'h004B_0000);

    // R3 invalidate
    cmd(2'd1, 16'd10, 32'h0);
    cmd(2'd2, 16'd10, 32'h0);
    chk("R3 invalid pattern", reg_rdata, 32'h0000_8000);
    xlate(32'h420A_0000, 1'b0);
    chk("R3 fault on invalid", {30'b0, xl_hit, xl_fault}, 32'd1);

    // R5 out-of-range index
    cmd(2'd0, 16'd300, 32'h0012_0000);
    chk("R5 err on map", {31'b0, reg_err}, 32'd1);
    cmd(2'd2, 16'd44, 32'h0);
    chk("R5 no alias write", reg_rdata, 32'h0000_8000);
    cmd(2'd2, 16'd256, 32'h0);
    chk("R5 err on read", {30'b0, reg_err, reg_rvalid}, 32'd2);

    // R1 R6 R7 translation vectors
    for (int v = 0; v < NV; v++) begin
      set_psize(V_PS[v]);
      cmd(2'd0, V_IDX[v], V_PA[v]);
      xlate(V_VA[v], V_DAT[v]);
      chk($sformatf("R1/R6 vec%0d rsp", v), {31'b0, xl_rsp}, 32'd1);
      chk($sformatf("R6/R7 vec%0d hit", v), {30'b0, xl_hit, xl_fault}, V_HIT[v] ? 32'd2 : 32'd1);
      chk($sformatf("R1/R7 vec%0d paddr", v), xl_paddr, V_EXP[v]);
    end

    // R9 first match with two candidates, R11 start while busy
    set_psize(2'd2);
    cmd(2'd0, 16'd40, 32'h0033_0000);
    cmd(2'd0, 16'd20, 32'h0033_0000);
    search(14'h0033, 1'b1, n);
    chk("R9 found", {31'b0, rl_found}, 32'd1);
    chk("R9 first index", {24'b0, rl_idx}, 32'd20);
    chk("R11 duration kept", n, 32'd21);
    @(negedge clk);
    chk("R11 no restart", {31'b0, rl_busy}, 32'd0);

    // R10 not found
    search(14'h3FFF, 1'b0, n);
    chk("R10 not found", {31'b0, rl_found}, 32'd0);
    chk("R10 idx ones", {24'b0, rl_idx}, 32'h0000_00FF);
    chk("R10 full scan", n, 32'd256);

    // R4 unmap all
    cmd(2'd3, 16'd0, 32'h0);
    cmd(2'd2, 16'd20, 32'h0);
    chk("R4 entry20 cleared", reg_rdata, 32'h0000_8000);
    cmd(2'd2, 16'd255, 32'h0);
    chk("R4 entry255 cleared", reg_rdata, 32'h0000_8000);
    xlate(32'h42FF_0010, 1'b0);
    chk("R4 translate faults", {30'b0, xl_hit, xl_fault}, 32'd1);
    search(14'h0000, 1'b0, n);
    chk("R4 no valid entry", {31'b0, rl_found}, 32'd0);

    // R12 region legality
    rg_start = 32'h3C00_0000; rg_len = 32'h0100_0000; rg_types = 2'b10; #1;
    chk("R12 full data window", {31'b0, rg_ok}, 32'd1);
    rg_len = 32'h0100_0001; #1;
    chk("R12 last byte outside", {31'b0, rg_ok}, 32'd0);
    rg_len = 32'h10; rg_types = 2'b01; #1;
    chk("R12 wrong window type", {31'b0, rg_ok}, 32'd0);
    rg_start = 32'h42FF_FFF0; rg_types = 2'b11; #1;
    chk("R12 instr window end", {31'b0, rg_ok}, 32'd1);
    rg_start = 32'h42FF_FFF1; #1;
    chk("R12 crosses window end", {31'b0, rg_ok}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule